// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps instructions that have been issued to speculative, out-of-order execution in a circular queue that follows program order. Issue reserves a slot and receives a tag, which is the slot's index. Results come back in any order on a broadcast port addressed by that tag. A result marks its slot finished but changes no architectural state. Architectural state changes only when the oldest slot retires. Register writes and store writes leave through the retire port, at most one per cycle, strictly from the head.

Speculation is resolved at the head. A branch whose result is flagged as mispredicted still retires, and every slot behind it is discarded in the same cycle. A slot whose result carries an exception does not retire. Instead it raises the exception when it becomes the oldest, so the exception is precise, and the whole queue is cleared. Depth, data width and register-index width are parameters, and the depth must be a power of two. Full and empty are derived from head and tail pointers that each carry one extra wrap bit.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `alloc_ready_o`=1, and `commit_valid_o`, `exc_o` and `flush_o` are 0.
- R2: Each accepted allocation receives the tag shown on `alloc_tag_o`. Tags run upward from 0 and wrap at DEPTH. With DEPTH slots occupied, `full_o`=1 and `alloc_ready_o`=0.
- R3: A finished slot does not retire while any older slot is unfinished. Results that arrive out of order retire in allocation order.
- R4: A result with `wb_valid_i`=1 marks the slot named by `wb_tag_i` finished. Its value is presented on `commit_value_o` when that slot retires, in the cycle after the result is accepted if the slot is then the oldest.
- R5: Operation codes are 0 ALU, 1 load, 2 store, 3 branch. ALU and load retire with `reg_we_o`=1 and `commit_dest_o` equal to the allocated register. A store retires with `store_en_o`=1 and `reg_we_o`=0. A branch retires with both at 0.
- R6: At most one slot retires per cycle. Consecutive finished slots retire on consecutive cycles.
- R7: A branch retiring with the mispredict flag set asserts `flush_o`. The younger slots never retire, the queue is empty in the next cycle, and the next tag is the one after the branch.
- R8: A slot that finished with the exception flag set raises `exc_o` when it is the oldest, with `commit_tag_o` naming it. It does not retire and asserts `flush_o`, and the queue is empty in the next cycle with the next tag equal to the faulting tag.
- R9: A result addressed to an unoccupied slot has no effect.
- R10: An allocation request while `full_o`=1 is ignored. It changes no tag and never retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Issue requests a slot |
| alloc_op_i | input | 2 | Operation code (0 ALU, 1 load, 2 store, 3 branch) |
| alloc_dest_i | input | RW | Destination register index |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_tag_o | output | log2(DEPTH) | Tag given to the current allocation |
| wb_valid_i | input | 1 | Broadcast result valid |
| wb_tag_i | input | log2(DEPTH) | Tag of the finished slot |
| wb_value_i | input | DW | Result or store data |
| wb_exc_i | input | 1 | Result carries an exception |
| wb_mispredict_i | input | 1 | Branch outcome was mispredicted |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_tag_o | output | log2(DEPTH) | Tag of the oldest slot |
| commit_dest_o | output | RW | Destination register of the retiring slot |
| commit_value_o | output | DW | Value of the retiring slot |
| reg_we_o | output | 1 | Register file write |
| store_en_o | output | 1 | Store to memory |
| exc_o | output | 1 | Precise exception raised by the oldest slot |
| flush_o | output | 1 | Queue is being cleared this cycle |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
All retire, exception and flush outputs are decoded from registered slot state, with no path from the inputs. A result taken at one rising edge therefore shows on the retire port right after that edge if its slot is the oldest, and a flush shows as an empty queue one edge later. The bench changes inputs just after a falling edge and reads outputs at the next falling edge. Every expectation is scheduled exactly one edge after the stimulus that causes it, plus one more edge per older slot still waiting ahead of it. A queued scoreboard holds only the retirements the requirements predict, so any extra or missing retirement shows up as a mismatch.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_BRANCH = 2'd3
  } rob_op_e;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clear_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [IW:0] head_q, tail_q, head_d;

  assign head_d = head_q + {{IW{1'b0}}, pop_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      // clear leaves tail just behind the surviving head
      tail_q <= clear_i ? head_d : tail_q + {{IW{1'b0}}, push_i};
    end
  end

  assign head_o  = head_q[IW-1:0];
  assign tail_o  = tail_q[IW-1:0];
  assign empty_o = (head_q == tail_q);
  assign full_o  = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);

  p_full_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i && !clear_i) |=> (full_o && $stable(tail_o)));
  p_not_both_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel
  import rob_pkg::*;
(
  input  logic    head_valid_i,
  input  logic    head_done_i,
  input  logic    head_exc_i,
  input  logic    head_misp_i,
  input  rob_op_e head_op_i,
  output logic    commit_o,
  output logic    reg_we_o,
  output logic    store_en_o,
  output logic    exc_o,
  output logic    clear_o
);
  logic ready;

  assign ready      = head_valid_i && head_done_i;
  assign exc_o      = ready && head_exc_i;
  assign commit_o   = ready && !head_exc_i;
  assign reg_we_o   = commit_o && (head_op_i == OP_ALU || head_op_i == OP_LOAD);
  assign store_en_o = commit_o && (head_op_i == OP_STORE);
  assign clear_o    = exc_o || (commit_o && head_op_i == OP_BRANCH && head_misp_i);
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned RW    = 5,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_valid_i,
  input  logic [1:0]    alloc_op_i,
  input  logic [RW-1:0] alloc_dest_i,
  output logic          alloc_ready_o,
  output logic [IW-1:0] alloc_tag_o,
  input  logic          wb_valid_i,
  input  logic [IW-1:0] wb_tag_i,
  input  logic [DW-1:0] wb_value_i,
  input  logic          wb_exc_i,
  input  logic          wb_mispredict_i,
  output logic          commit_valid_o,
  output logic [IW-1:0] commit_tag_o,
  output logic [RW-1:0] commit_dest_o,
  output logic [DW-1:0] commit_value_o,
  output logic          reg_we_o,
  output logic          store_en_o,
  output logic          exc_o,
  output logic          flush_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DEPTH-1:0] valid_q, done_q, exc_q, misp_q;
  rob_op_e          op_q   [DEPTH];
  logic [RW-1:0]    dest_q [DEPTH];
  logic [DW-1:0]    val_q  [DEPTH];

  logic [IW-1:0] head, tail;
  logic          alloc_fire, commit_fire, clear;

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (commit_fire),
    .clear_i (clear),
    .head_o  (head),
    .tail_o  (tail),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  rob_commit_sel u_sel (
    .head_valid_i (valid_q[head]),
    .head_done_i  (done_q[head]),
    .head_exc_i   (exc_q[head]),
    .head_misp_i  (misp_q[head]),
    .head_op_i    (op_q[head]),
    .commit_o     (commit_fire),
    .reg_we_o     (reg_we_o),
    .store_en_o   (store_en_o),
    .exc_o        (exc_o),
    .clear_o      (clear)
  );

  assign alloc_ready_o = !full_o && !clear;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_tag_o   = tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      misp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i]   <= OP_ALU;
        dest_q[i] <= '0;
        val_q[i]  <= '0;
      end
    end else if (clear) begin
      // head is retired or faulting; every other slot is younger
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (commit_fire && head == IW'(i)) valid_q[i] <= 1'b0;
        if (wb_valid_i && wb_tag_i == IW'(i) && valid_q[i]) begin
          done_q[i] <= 1'b1;
          val_q[i]  <= wb_value_i;
          exc_q[i]  <= wb_exc_i;
          misp_q[i] <= wb_mispredict_i;
        end
        if (alloc_fire && tail == IW'(i)) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          exc_q[i]   <= 1'b0;
          misp_q[i]  <= 1'b0;
          op_q[i]    <= rob_op_e'(alloc_op_i);
          dest_q[i]  <= alloc_dest_i;
        end
      end
    end
  end

  assign commit_valid_o = commit_fire;
  assign commit_tag_o   = head;
  assign commit_dest_o  = dest_q[head];
  assign commit_value_o = val_q[head];
  assign flush_o        = clear;

  p_empty_none_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (valid_q == '0));
  p_full_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (&valid_q));
  p_in_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> (commit_tag_o == IW'($past(commit_tag_o) + 1'b1)));
  p_one_kind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, store_en_o, exc_o}));
  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> empty_o);
  p_exc_no_retire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !commit_valid_o);
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int DEPTH = 8;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int IW = 3;

  typedef struct packed {
    logic [IW-1:0] tag;
    logic [1:0]    op;
    logic [RW-1:0] dest;
    logic [DW-1:0] val;
    logic          exc;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, wb_valid = 0, wb_exc = 0, wb_misp = 0;
  logic [1:0] alloc_op = 0;
  logic [RW-1:0] alloc_dest = 0;
  logic [IW-1:0] wb_tag = 0;
  logic [DW-1:0] wb_value = 0;
  logic alloc_ready, commit_valid, reg_we, store_en, exc, flush, full, empty;
  logic [IW-1:0] alloc_tag, commit_tag;
  logic [RW-1:0] commit_dest;
  logic [DW-1:0] commit_value;

  int total = 0, fails = 0, serial = 0;
  bit mon_en = 0;
  exp_t exp_q[$];
  logic [DW-1:0] val_of [DEPTH];

  always #10 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_op_i(alloc_op), .alloc_dest_i(alloc_dest),
    .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_value_i(wb_value),
    .wb_exc_i(wb_exc), .wb_mispredict_i(wb_misp),
    .commit_valid_o(commit_valid), .commit_tag_o(commit_tag), .commit_dest_o(commit_dest),
    .commit_value_o(commit_value), .reg_we_o(reg_we), .store_en_o(store_en),
    .exc_o(exc), .flush_o(flush), .full_o(full), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle per call: starts and ends just after a falling edge
  task automatic do_alloc(input logic [1:0] op, input logic [RW-1:0] d,
                          input bit expect_retire, input bit will_fault,
                          output logic [IW-1:0] tag);
    exp_t e;
    alloc_valid = 1; alloc_op = op; alloc_dest = d;
    tag = alloc_tag;
    serial++;
    val_of[tag] = 32'h0001_0000 * serial + 32'(tag);
    if (expect_retire) begin
      e.tag = tag; e.op = op; e.dest = d; e.val = val_of[tag]; e.exc = will_fault;
      exp_q.push_back(e);
    end
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_wb(input logic [IW-1:0] t, input bit ex, input bit mp);
    wb_valid = 1; wb_tag = t; wb_value = val_of[t]; wb_exc = ex; wb_misp = mp;
    @(negedge clk);
    wb_valid = 0; wb_exc = 0; wb_misp = 0;
  endtask

  // scoreboard monitor: every retirement or exception must match the queue front
  always @(negedge clk) begin
    if (mon_en && (commit_valid || exc)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3", "unexpected retire tag", 64'(commit_tag), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(commit_tag == e.tag, "R3", "retire order tag", 64'(commit_tag), 64'(e.tag));
        chk(exc == e.exc, "R8", "exception flag", 64'(exc), 64'(e.exc));
        if (!e.exc) begin
          chk(reg_we == (e.op == 2'd0 || e.op == 2'd1), "R5", "reg_we", 64'(reg_we),
              64'(e.op == 2'd0 || e.op == 2'd1));
          chk(store_en == (e.op == 2'd2), "R5", "store_en", 64'(store_en), 64'(e.op == 2'd2));
          if (e.op != 2'd3)
            chk(commit_value == e.val, "R4", "value", 64'(commit_value), 64'(e.val));
          if (e.op < 2'd2)
            chk(commit_dest == e.dest, "R5", "dest", 64'(commit_dest), 64'(e.dest));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [IW-1:0] t [8];
    logic [IW-1:0] tx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    // R1 reset state
    chk(empty == 1 && full == 0, "R1", "empty/full", {full, empty}, 2'b01);
    chk(alloc_ready == 1 && commit_valid == 0 && exc == 0 && flush == 0, "R1", "idle outputs",
        {alloc_ready, commit_valid, exc, flush}, 4'b1000);

    // R2 R3 R4 R5 R6: out-of-order results, in-order retirement
    do_alloc(2'd0, 5'd1, 1, 0, t[0]);
    do_alloc(2'd1, 5'd2, 1, 0, t[1]);
    do_alloc(2'd2, 5'd3, 1, 0, t[2]);
    do_alloc(2'd0, 5'd4, 1, 0, t[3]);
    for (int k = 0; k < 4; k++) chk(t[k] == IW'(k), "R2", "tag sequence", 64'(t[k]), 64'(k));
    do_wb(t[3], 0, 0);
    do_wb(t[1], 0, 0);
    do_wb(t[2], 0, 0);
    chk(commit_valid == 0, "R3", "no retire while head unfinished", 64'(commit_valid), 0);
    do_wb(t[0], 0, 0);
    for (int k = 0; k < 4; k++) begin
      chk(commit_valid == 1 && commit_tag == IW'(k), "R6", "one retire per cycle",
          {commit_valid, commit_tag}, {1'b1, 3'(k)});
      @(negedge clk);
    end
    chk(empty == 1, "R6", "drained", 64'(empty), 1);

    // R2 R10: fill, reject extra allocation
    for (int k = 0; k < 8; k++) do_alloc(2'(k % 3), 5'(k + 8), 1, 0, t[k]);
    chk(full == 1 && alloc_ready == 0, "R2", "full", {full, alloc_ready}, 2'b10);
    alloc_valid = 1; alloc_op = 2'd2; alloc_dest = 5'd30;
    @(negedge clk);
    alloc_valid = 0;
    chk(full == 1 && alloc_tag == 3'd4, "R10", "tail unchanged when full", {full, alloc_tag}, {1'b1, 3'd4});
    for (int k = 0; k < 8; k++) do_wb(t[k], 0, 0);
    repeat (3) @(negedge clk);
    chk(empty == 1 && exp_q.size() == 0, "R10", "no extra retire", 64'(exp_q.size()), 0);
    chk(alloc_tag == 3'd4, "R2", "tag wrapped", 64'(alloc_tag), 4);

    // R9: result to unoccupied slot ignored
    do_alloc(2'd0, 5'd5, 1, 0, t[0]);
    val_of[5] = 32'hDEAD_BEEF;
    do_wb(3'd5, 0, 0);
    do_alloc(2'd0, 5'd6, 1, 0, t[1]);
    do_wb(t[0], 0, 0);
    chk(commit_valid == 1 && commit_tag == 3'd4, "R4", "retire after result", {commit_valid, commit_tag}, {1'b1, 3'd4});
    @(negedge clk);
    chk(commit_valid == 0, "R9", "stray result did not finish slot", 64'(commit_valid), 0);
    do_wb(t[1], 0, 0);
    @(negedge clk);

    // R7: mispredicted branch at head
    do_alloc(2'd3, 5'd0, 1, 0, t[0]);
    do_alloc(2'd0, 5'd7, 0, 0, t[1]);
    do_alloc(2'd2, 5'd8, 0, 0, t[2]);
    do_wb(t[1], 0, 0);
    do_wb(t[2], 0, 0);
    chk(commit_valid == 0, "R3", "young slots wait for branch", 64'(commit_valid), 0);
    do_wb(t[0], 0, 1);
    chk(commit_valid == 1 && flush == 1 && alloc_ready == 0, "R7", "branch retires with flush",
        {commit_valid, flush, alloc_ready}, 3'b110);
    @(negedge clk);
    chk(empty == 1 && commit_valid == 0, "R7", "younger discarded", {empty, commit_valid}, 2'b10);
    chk(alloc_tag == IW'(t[0] + 1), "R7", "next tag", 64'(alloc_tag), 64'(IW'(t[0] + 1)));

    // R8: precise exception
    do_alloc(2'd0, 5'd9, 1, 0, t[0]);
    do_alloc(2'd0, 5'd10, 1, 1, t[1]);
    do_alloc(2'd1, 5'd11, 0, 0, t[2]);
    do_wb(t[2], 0, 0);
    do_wb(t[0], 0, 0);
    do_wb(t[1], 1, 0);
    chk(exc == 1 && commit_valid == 0 && flush == 1 && commit_tag == t[1], "R8", "exception at head",
        {exc, commit_valid, flush, commit_tag}, {3'b101, t[1]});
    tx = t[1];
    @(negedge clk);
    chk(empty == 1 && exc == 0 && alloc_tag == tx, "R8", "cleared, tail at faulting tag",
        {empty, exc, alloc_tag}, {2'b10, tx});
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all predicted retires seen", 64'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule